// File: doc/BRIEF.md
# Enhanced-Mode Floppy Controller Register Bank

This block is the register bank that a floppy disk controller exposes once its legacy port has been unlocked. It shares the controller's 8 KiB address window with that legacy port: the register index is taken from address bits above bit 9, so each register occupies a 512-byte slot. Indices 0 to 7 are write registers and indices 8 to 15 are read registers. The bank holds a drive phase register and an 8-bit mode register. The mode register is changed only through two addresses: one clears the bits given in the data and the other sets them. The bank also holds a 16-byte parameter memory that both its read port and its write port walk with one shared pointer.

The legacy port sends a one-cycle unlock pulse. The pulse sets the mode-active bit (bit 6), and the bank answers accesses from the next cycle on. When software clears bit 6 through the clear address, the bank goes inactive. On the following cycle it raises a one-cycle request for the legacy port to take over again and clear its latches. Reads are combinational: read data is valid in the cycle of the access. Side effects such as pointer movement take effect at the closing clock edge. The data FIFO, mark and CRC logic, and real drive signals are not part of this block.

Top module: `enh_regbank`

## Requirements
- R1: After reset the mode register, the phase register, the parameter pointer and all 16 parameter bytes are 0. The bank is inactive, the legacy request is low and the read data is 0.
- R2: The register index is address bits [12:9], and the address bits below bit 9 have no effect. While the bank is inactive, an access has no effect on any register and reads as 0. Read data is 0 in any cycle without a read access.
- R3: A unlock pulse sets mode bit 6 (0x40) and keeps the other mode bits. The bank is active from the cycle after the pulse.
- R4: A write to index 4 loads the phase register. A read of index 12 returns it.
- R5: A write to index 6 clears each mode bit that is 1 in the data. Any access to index 6, read or write, returns the parameter pointer to 0.
- R6: When a write to index 6 leaves mode bit 6 at 0, the bank is inactive from the next cycle. The legacy request is high for exactly that one cycle.
- R7: A write to index 7 sets each mode bit that is 1 in the data and leaves the other bits unchanged.
- R8: A write to index 3 stores the byte at the pointer. A read of index 11 returns the byte at the pointer. Both advance the same pointer by one, modulo 16.
- R9: A read of index 15 returns 0x08 when the phase register holds 0x77, and 0x00 for any other phase value.
- R10: A read of index 14 returns the status byte (0 in this bank) with bit 6 set to the active flag, so an active bank reads 0x40.
- R11: Writes to indices 0, 1, 2 and 5 change nothing. Reads of indices 8, 9, 10 and 13 return 0. A read of a write index (0 to 7) returns 0, and a write to a read index (8 to 15) changes nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| unlock_i | input | 1 | One-cycle unlock pulse from the legacy port |
| acc_valid_i | input | 1 | Access strobe, one access per cycle |
| acc_write_i | input | 1 | 1 for a write, 0 for a read |
| acc_addr_i | input | ADDR_W (13) | Byte address within the window |
| acc_wdata_i | input | 8 | Write data |
| acc_rdata_o | output | 8 | Read data, valid in the cycle of the read |
| mode_o | output | 8 | Current mode register |
| enh_active_o | output | 1 | Bank is active (mode bit 6) |
| legacy_req_o | output | 1 | One-cycle request to return to the legacy port |

## Verification
The bench builds the bank with its default parameters: a 13-bit address, a shift of 9 and a 16-byte parameter memory. With these values the bench can wrap the shared pointer after 16 writes and check that the 17th write lands on entry 0. Random low address bits on every access check that only bits [12:9] select the register. A reference model compares the outputs on every access. It covers the pointer being reset by a read of the clear address, the fall out of active mode with its one-cycle request, and a second unlock that keeps the other mode bits.

// File: rtl/enh_pkg.sv
package enh_pkg;

    localparam int unsigned BYTE_W = 8;
    localparam int unsigned IDX_W  = 4;

    // write register indices
    localparam logic [IDX_W-1:0] W_DATA     = 4'd0;
    localparam logic [IDX_W-1:0] W_MARK     = 4'd1;
    localparam logic [IDX_W-1:0] W_CRC      = 4'd2;
    localparam logic [IDX_W-1:0] W_PARAM    = 4'd3;
    localparam logic [IDX_W-1:0] W_PHASE    = 4'd4;
    localparam logic [IDX_W-1:0] W_SETUP    = 4'd5;
    localparam logic [IDX_W-1:0] W_MODE_CLR = 4'd6;
    localparam logic [IDX_W-1:0] W_MODE_SET = 4'd7;
    // read register indices
    localparam logic [IDX_W-1:0] R_PARAM     = 4'd11;
    localparam logic [IDX_W-1:0] R_PHASE     = 4'd12;
    localparam logic [IDX_W-1:0] R_STATUS    = 4'd14;
    localparam logic [IDX_W-1:0] R_HANDSHAKE = 4'd15;

    localparam int unsigned ACTIVE_BIT = 6;
    localparam logic [BYTE_W-1:0] DRIVE_QUERY  = 8'h77;
    localparam logic [BYTE_W-1:0] SENSE_ANSWER = 8'h08;
    localparam logic [BYTE_W-1:0] STATUS_BASE  = 8'h00;

    typedef struct packed {
        logic              valid;   // qualified by the active flag
        logic              write;
        logic [IDX_W-1:0]  idx;
        logic [BYTE_W-1:0] data;
    } acc_t;

    function automatic logic is_wr(acc_t a, logic [IDX_W-1:0] i);
        return a.valid && a.write && (a.idx == i);
    endfunction

    function automatic logic is_rd(acc_t a, logic [IDX_W-1:0] i);
        return a.valid && !a.write && (a.idx == i);
    endfunction

endpackage

// File: rtl/enh_mode_ctl.sv
module enh_mode_ctl
    import enh_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              unlock_i,
    input  acc_t              acc_i,
    output logic [BYTE_W-1:0] mode_o,
    output logic              legacy_req_o
);
    logic [BYTE_W-1:0] mode_q;
    logic [BYTE_W-1:0] mode_nx;
    logic              drop;

    always_comb begin
        mode_nx = mode_q;
        if (is_wr(acc_i, W_MODE_CLR)) mode_nx = mode_q & ~acc_i.data;
        if (is_wr(acc_i, W_MODE_SET)) mode_nx = mode_q | acc_i.data;
        if (unlock_i)                 mode_nx[ACTIVE_BIT] = 1'b1;
        drop = is_wr(acc_i, W_MODE_CLR) && !mode_nx[ACTIVE_BIT];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q       <= '0;
            legacy_req_o <= 1'b0;
        end else begin
            mode_q       <= mode_nx;
            legacy_req_o <= drop;
        end
    end

    assign mode_o = mode_q;
endmodule

// File: rtl/enh_param_mem.sv
module enh_param_mem
    import enh_pkg::*;
#(
    parameter int unsigned DEPTH = 16,
    localparam int unsigned PTR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  acc_t              acc_i,
    output logic [BYTE_W-1:0] byte_o,
    output logic [PTR_W-1:0]  ptr_o
);
    logic [BYTE_W-1:0] mem_q [DEPTH];
    logic [PTR_W-1:0]  ptr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr_q <= '0;
        end else if (acc_i.valid && acc_i.idx == W_MODE_CLR) begin
            ptr_q <= '0;
        end else if (is_wr(acc_i, W_PARAM) || is_rd(acc_i, R_PARAM)) begin
            ptr_q <= ptr_q + 1'b1;
        end
    end

    for (genvar g = 0; g < DEPTH; g++) begin : g_cell
        always_ff @(posedge clk) begin
            if (rst)
                mem_q[g] <= '0;
            else if (is_wr(acc_i, W_PARAM) && ptr_q == PTR_W'(g))
                mem_q[g] <= acc_i.data;
        end
    end

    assign byte_o = mem_q[ptr_q];
    assign ptr_o  = ptr_q;
endmodule

// File: rtl/enh_read_mux.sv
module enh_read_mux
    import enh_pkg::*;
(
    input  acc_t              acc_i,
    input  logic              active_i,
    input  logic [BYTE_W-1:0] phase_i,
    input  logic [BYTE_W-1:0] param_i,
    output logic [BYTE_W-1:0] rdata_o
);
    logic [BYTE_W-1:0] status;

    always_comb begin
        status             = STATUS_BASE;
        status[ACTIVE_BIT] = active_i;
        rdata_o            = '0;
        if (acc_i.valid && !acc_i.write) begin
            unique case (acc_i.idx)
                R_PHASE:     rdata_o = phase_i;
                R_PARAM:     rdata_o = param_i;
                R_STATUS:    rdata_o = status;
                R_HANDSHAKE: rdata_o = (phase_i == DRIVE_QUERY) ? SENSE_ANSWER : '0;
                default:     rdata_o = '0;
            endcase
        end
    end
endmodule

// File: rtl/enh_regbank.sv
module enh_regbank
    import enh_pkg::*;
#(
    parameter int unsigned ADDR_W     = 13,
    parameter int unsigned REG_SHIFT  = 9,
    parameter int unsigned PRAM_DEPTH = 16,
    localparam int unsigned PTR_W     = $clog2(PRAM_DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              unlock_i,
    input  logic              acc_valid_i,
    input  logic              acc_write_i,
    input  logic [ADDR_W-1:0] acc_addr_i,
    input  logic [7:0]        acc_wdata_i,
    output logic [7:0]        acc_rdata_o,
    output logic [7:0]        mode_o,
    output logic              enh_active_o,
    output logic              legacy_req_o
);
    acc_t              acc;
    logic [IDX_W-1:0]  acc_idx;
    logic [BYTE_W-1:0] phase_q;
    logic [BYTE_W-1:0] param_byte;
    logic [PTR_W-1:0]  ptr;

    assign acc_idx      = acc_addr_i[REG_SHIFT +: IDX_W];
    assign enh_active_o = mode_o[ACTIVE_BIT];

    always_comb begin
        acc.valid = acc_valid_i && enh_active_o;
        acc.write = acc_write_i;
        acc.idx   = acc_idx;
        acc.data  = acc_wdata_i;
    end

    always_ff @(posedge clk) begin
        if (rst)
            phase_q <= '0;
        else if (is_wr(acc, W_PHASE))
            phase_q <= acc.data;
    end

    enh_mode_ctl u_mode (
        .clk(clk), .rst(rst), .unlock_i(unlock_i), .acc_i(acc),
        .mode_o(mode_o), .legacy_req_o(legacy_req_o)
    );

    enh_param_mem #(.DEPTH(PRAM_DEPTH)) u_pmem (
        .clk(clk), .rst(rst), .acc_i(acc),
        .byte_o(param_byte), .ptr_o(ptr)
    );

    enh_read_mux u_rmux (
        .acc_i(acc), .active_i(enh_active_o), .phase_i(phase_q),
        .param_i(param_byte), .rdata_o(acc_rdata_o)
    );
endmodule

// File: rtl/enh_regbank_chk.sv
module enh_regbank_chk #(
    parameter int unsigned PTR_W = 4
) (
    input logic             clk,
    input logic             rst,
    input logic             unlock_i,
    input logic             acc_valid_i,
    input logic             acc_write_i,
    input logic [3:0]       idx,
    input logic [7:0]       acc_wdata_i,
    input logic [7:0]       acc_rdata_o,
    input logic [7:0]       mode_o,
    input logic             enh_active_o,
    input logic             legacy_req_o,
    input logic [7:0]       phase,
    input logic [PTR_W-1:0] ptr
);
    logic act_acc;
    assign act_acc = acc_valid_i && enh_active_o;

    a_r2_idle_zero: assert property (@(posedge clk) disable iff (rst)
        !(act_acc && !acc_write_i) |-> acc_rdata_o == 8'h00);

    a_r3_unlock_activates: assert property (@(posedge clk) disable iff (rst)
        unlock_i |=> enh_active_o);

    a_r5_ptr_cleared: assert property (@(posedge clk) disable iff (rst)
        (act_acc && idx == 4'd6) |=> ptr == '0);

    a_r6_req_single: assert property (@(posedge clk) disable iff (rst)
        legacy_req_o |=> !legacy_req_o);

    a_r6_req_inactive: assert property (@(posedge clk) disable iff (rst)
        legacy_req_o |-> !enh_active_o);

    a_r7_bits_set: assert property (@(posedge clk) disable iff (rst)
        (act_acc && acc_write_i && idx == 4'd7) |=>
        (mode_o & $past(acc_wdata_i)) == $past(acc_wdata_i));

    a_r8_ptr_step: assert property (@(posedge clk) disable iff (rst)
        (act_acc && ((acc_write_i && idx == 4'd3) || (!acc_write_i && idx == 4'd11)))
        |=> ptr == PTR_W'($past(ptr) + 1'b1));

    a_r9_handshake: assert property (@(posedge clk) disable iff (rst)
        (act_acc && !acc_write_i && idx == 4'd15) |->
        acc_rdata_o == ((phase == 8'h77) ? 8'h08 : 8'h00));
endmodule

bind enh_regbank enh_regbank_chk #(.PTR_W(PTR_W)) u_chk (
    .clk(clk), .rst(rst), .unlock_i(unlock_i), .acc_valid_i(acc_valid_i),
    .acc_write_i(acc_write_i), .idx(acc_idx), .acc_wdata_i(acc_wdata_i),
    .acc_rdata_o(acc_rdata_o), .mode_o(mode_o), .enh_active_o(enh_active_o),
    .legacy_req_o(legacy_req_o), .phase(phase_q), .ptr(ptr)
);

// File: tb/enh_regbank_bench.sv
module enh_regbank_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        unlock_i = 1'b0;
    logic        acc_valid_i = 1'b0;
    logic        acc_write_i = 1'b0;
    logic [12:0] acc_addr_i = '0;
    logic [7:0]  acc_wdata_i = '0;
    logic [7:0]  acc_rdata_o;
    logic [7:0]  mode_o;
    logic        enh_active_o;
    logic        legacy_req_o;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // reference model state
    int m_mode = 0, m_phase = 0, m_ptr = 0, m_req = 0;
    int m_mem[16];

    always #4 clk = ~clk;

    enh_regbank u_enh_regbank (.*);

    task automatic check(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic int model_read(bit v, bit wr, int idx);
        if (!v || wr || ((m_mode >> 6) & 1) == 0) return 0;
        case (idx)
            12: return m_phase;
            11: return m_mem[m_ptr];
            14: return 8'h40;
            15: return (m_phase == 8'h77) ? 8'h08 : 0;
            default: return 0;
        endcase
    endfunction

    task automatic step(bit v, bit wr, int idx, int d, bit unl, string tag);
        int nm, np, nreq;
        bit act;
        @(negedge clk);
        acc_valid_i = v; acc_write_i = wr; unlock_i = unl;
        acc_wdata_i = d[7:0];
        acc_addr_i  = {idx[3:0], 9'($urandom)};
        #1;
        check({tag, " rdata"}, acc_rdata_o, model_read(v, wr, idx));
        act = ((m_mode >> 6) & 1) == 1;
        nm = m_mode; np = m_ptr; nreq = 0;
        if (v && act) begin
            if (wr && idx == 4) m_phase = d & 8'hff;
            if (wr && idx == 6) nm = m_mode & ~d & 8'hff;
            if (wr && idx == 7) nm = (m_mode | d) & 8'hff;
            if (wr && idx == 3) begin m_mem[m_ptr] = d & 8'hff; np = (m_ptr + 1) % 16; end
            if (!wr && idx == 11) np = (m_ptr + 1) % 16;
            if (idx == 6) np = 0;
        end
        if (unl) nm = nm | 8'h40;
        if (v && act && wr && idx == 6 && ((nm >> 6) & 1) == 0) nreq = 1;
        @(posedge clk); #1;
        m_mode = nm; m_ptr = np; m_req = nreq;
        acc_valid_i = 0; unlock_i = 0;
        check({tag, " mode"}, mode_o, m_mode);
        check({tag, " active"}, enh_active_o, (m_mode >> 6) & 1);
        check({tag, " legacy_req"}, legacy_req_o, m_req);
    endtask

    initial begin
        #(8 * 150000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        foreach (m_mem[i]) m_mem[i] = 0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 0;
        #1;
        // R1 reset state
        check("R1 mode", mode_o, 0);
        check("R1 active", enh_active_o, 0);
        check("R1 legacy_req", legacy_req_o, 0);
        check("R1 rdata", acc_rdata_o, 0);
        // R2 accesses while inactive are ignored
        step(1, 1, 4, 8'h55, 0, "R2 phase write inactive");
        step(1, 1, 7, 8'h0f, 0, "R2 set write inactive");
        step(1, 0, 14, 0, 0, "R2 status read inactive");
        // R3 unlock
        step(0, 0, 0, 0, 1, "R3 unlock");
        step(1, 0, 12, 0, 0, "R1 R2 phase still zero");
        step(1, 0, 11, 0, 0, "R1 param zero");
        step(1, 0, 14, 0, 0, "R10 status active");
        // R4, R9
        step(1, 1, 4, 8'h77, 0, "R4 phase write");
        step(1, 0, 12, 0, 0, "R4 phase read");
        step(1, 0, 15, 0, 0, "R9 sense answer");
        step(1, 1, 4, 8'h76, 0, "R4 phase near query");
        step(1, 0, 15, 0, 0, "R9 no sense");
        step(0, 0, 0, 0, 0, "R2 idle");
        // R7, R5
        step(1, 1, 7, 8'h81, 0, "R7 set bits");
        step(1, 1, 6, 8'h01, 0, "R5 clear bit0");
        // R8 parameter memory and wrap
        step(1, 1, 6, 8'h00, 0, "R5 pointer home");
        for (int i = 0; i < 17; i++) step(1, 1, 3, 8'h10 + i, 0, "R8 param write");
        step(1, 0, 6, 0, 0, "R5 read resets pointer");
        for (int i = 0; i < 18; i++) step(1, 0, 11, 0, 0, "R8 param read");
        step(1, 1, 3, 8'hAB, 0, "R8 write after reads");
        step(1, 1, 6, 8'h00, 0, "R5 clear nothing");
        step(1, 0, 11, 0, 0, "R8 read after pointer reset");
        // R11 ignored indices
        step(1, 1, 0, 8'hff, 0, "R11 data write");
        step(1, 1, 1, 8'hff, 0, "R11 mark write");
        step(1, 1, 2, 8'hff, 0, "R11 crc write");
        step(1, 1, 5, 8'hff, 0, "R11 setup write");
        step(1, 1, 12, 8'h33, 0, "R11 write to read index");
        for (int i = 0; i < 11; i++) step(1, 0, i, 0, 0, "R11 reads");
        step(1, 0, 13, 0, 0, "R11 setup read");
        step(1, 0, 12, 0, 0, "R11 phase untouched");
        step(1, 0, 11, 0, 0, "R11 param untouched");
        // R6 leave enhanced mode
        step(1, 1, 6, 8'h40, 0, "R6 clear active bit");
        step(1, 0, 14, 0, 0, "R6 inactive status");
        step(1, 1, 7, 8'h40, 0, "R6 set ignored while inactive");
        // R3 second unlock keeps other bits
        step(0, 0, 0, 0, 1, "R3 unlock again");
        step(1, 0, 12, 0, 0, "R4 phase kept");
        // unlock together with a clear of bit 6
        step(1, 1, 6, 8'h40, 1, "R6 unlock wins");
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule